// File: doc/BRIEF.md
# GPIO Wake Event Status Latch

This block watches the pins of several GPIO ports (two by default) and records wake events in a status register per port. Each pin has a 3-bit trigger mode. The mode selects a high level, a low level, a rising edge, a falling edge, or nothing at all. The pins are brought into the clock domain through a synchroniser chain. Edges are found by comparing the synchronised value with a registered copy of itself.

When a pin's event fires, its bit in its own port's status register is set. A port's interrupt stays high for as long as any bit of that port is set. All status vectors are also driven out together as a flat bus, so a power controller can tell which pin caused the wake-up. Software reads a port's status through a select input. It acknowledges an event by writing a clear mask to one port. If a clear and a new event hit the same bit in the same cycle, the event wins.

Top module: `gpio_wake_latch`

## Requirements
- R1: While reset is asserted, and after it is released, every status bit and every port interrupt is 0.
- R2: Mode code 1 (high level) sets the pin's status bit in the third rising clock edge after the pin goes high, and not earlier. While the pin stays high, the bit is set again every cycle, so a clear has no lasting effect.
- R3: Mode code 2 (low level) sets the pin's status bit while the synchronised pin is low.
- R4: Mode code 3 (rising edge) sets the bit once per 0-to-1 transition. After a clear, the bit stays 0 while the pin remains high.
- R5: Mode code 4 (falling edge) sets the bit once per 1-to-0 transition. A 0-to-1 transition does not set it.
- R6: Mode code 0 and the unused codes 5, 6 and 7 never set a status bit, whatever the pin does.
- R7: An event on a pin sets only the bit of that pin, in the status of that pin's own port.
- R8: The interrupt of port p is 1 exactly when at least one status bit of port p is 1.
- R9: A clear write with port select p and a mask clears exactly the masked bits of port p, one edge later. Other bits of p and all other ports keep their values. For example, mask 0x1 clears pin 0.
- R10: When a clear and a new event target the same bit in the same cycle, the bit stays 1.
- R11: The status bus carries the status of port p in bits [p*PIN_W +: PIN_W]. The read data output returns the status of the port named by the read select.
- R12: The mode of pin i of port p occupies bits [3*(p*PIN_W+i) +: 3] of the mode input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | N_PORTS*PIN_W | GPIO pin levels; port p in bits [p*PIN_W +: PIN_W] |
| mode_i | input | N_PORTS*PIN_W*3 | Per-pin trigger mode codes |
| clr_we_i | input | 1 | Clear strobe, one cycle per write |
| clr_port_i | input | SEL_W | Port targeted by the clear |
| clr_mask_i | input | PIN_W | Bits to clear in the targeted port |
| rd_sel_i | input | SEL_W | Port whose status appears on rd_data_o |
| rd_data_o | output | PIN_W | Status of the selected port |
| irq_o | output | N_PORTS | One interrupt per port |
| status_bus_o | output | N_PORTS*PIN_W | All port status vectors for the power controller |

## Verification
On every cycle, the checker confirms four things. Each port interrupt matches the OR of that port's slice of the status bus. A status bit never drops unless that port was cleared in the previous cycle. No bit rises unless its pin had a valid trigger code. The read data always equals the selected slice of the bus. The bench scenarios show what a per-cycle property cannot see without internal state: the exact three-edge latency, the difference between level re-setting and one-shot edges, the direction of each edge, the collision of a clear with a fresh event, and the clearing of state by a reset in the middle of a run.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    TRIG_OFF  = 3'd0,
    TRIG_HIGH = 3'd1,
    TRIG_LOW  = 3'd2,
    TRIG_RISE = 3'd3,
    TRIG_FALL = 3'd4
  } trig_mode_e;
endpackage

// File: rtl/wkup_rst_sync.sv
module wkup_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] rs_q;
  logic [STAGES-1:0] rs_d;

  always_comb begin
    rs_d = {rs_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= '0;
    else         rs_q <= rs_d;
  end

  assign rst_sync_no = rs_q[STAGES-1];
endmodule

// File: rtl/gpio_sync_stage.sv
module gpio_sync_stage #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  localparam int DEPTH = STAGES + 1;

  logic [W-1:0] chain_q [DEPTH];
  logic [W-1:0] chain_d [DEPTH];

  always_comb begin
    chain_d[0] = pins_i;
    for (int s = 1; s < DEPTH; s++) chain_d[s] = chain_q[s-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < DEPTH; s++) chain_q[s] <= '0;
    end else begin
      for (int s = 0; s < DEPTH; s++) chain_q[s] <= chain_d[s];
    end
  end

  assign sync_o = chain_q[STAGES-1];
  assign prev_o = chain_q[STAGES];
endmodule

// File: rtl/pin_event_decode.sv
module pin_event_decode
  import wkup_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]        sync_i,
  input  logic [W-1:0]        prev_i,
  input  logic [W*MODE_W-1:0] mode_i,
  output logic [W-1:0]        evt_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    trig_mode_e code;
    assign code = trig_mode_e'(mode_i[MODE_W*i +: MODE_W]);

    always_comb begin
      unique case (code)
        TRIG_HIGH: evt_o[i] = sync_i[i];
        TRIG_LOW:  evt_o[i] = ~sync_i[i];
        TRIG_RISE: evt_o[i] = sync_i[i] & ~prev_i[i];
        TRIG_FALL: evt_o[i] = ~sync_i[i] & prev_i[i];
        default:   evt_o[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/port_status_reg.sv
module port_status_reg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_mask_i,
  output logic [W-1:0] status_o,
  output logic         irq_o
);
  logic [W-1:0] status_q;
  logic [W-1:0] status_d;
  logic [W-1:0] clr_vec;
  logic         upd_en;

  always_comb begin
    clr_vec  = clr_en_i ? clr_mask_i : '0;
    status_d = (status_q & ~clr_vec) | evt_i;
    upd_en   = clr_en_i | (|evt_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     status_q <= '0;
    else if (upd_en) status_q <= status_d;
  end

  assign status_o = status_q;
  assign irq_o    = |status_q;
endmodule

// File: rtl/gpio_wake_latch.sv
module gpio_wake_latch
  import wkup_pkg::*;
#(
  parameter int  N_PORTS     = 2,
  parameter int  PIN_W       = 16,
  parameter int  SYNC_STAGES = 2,
  localparam int SEL_W       = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [N_PORTS*PIN_W-1:0]        pins_i,
  input  logic [N_PORTS*PIN_W*MODE_W-1:0] mode_i,
  input  logic                            clr_we_i,
  input  logic [SEL_W-1:0]                clr_port_i,
  input  logic [PIN_W-1:0]                clr_mask_i,
  input  logic [SEL_W-1:0]                rd_sel_i,
  output logic [PIN_W-1:0]                rd_data_o,
  output logic [N_PORTS-1:0]              irq_o,
  output logic [N_PORTS*PIN_W-1:0]        status_bus_o
);
  localparam int PORT_MODE_W = PIN_W * MODE_W;

  logic             rst_core_n;
  logic [PIN_W-1:0] stat [N_PORTS];

  wkup_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_core_n)
  );

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    logic [PIN_W-1:0] sync_v;
    logic [PIN_W-1:0] prev_v;
    logic [PIN_W-1:0] evt_v;
    logic             clr_hit;

    assign clr_hit = clr_we_i && (clr_port_i == SEL_W'(p));

    gpio_sync_stage #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_core_n),
      .pins_i (pins_i[p*PIN_W +: PIN_W]),
      .sync_o (sync_v),
      .prev_o (prev_v)
    );

    pin_event_decode #(.W(PIN_W)) u_decode (
      .sync_i (sync_v),
      .prev_i (prev_v),
      .mode_i (mode_i[p*PORT_MODE_W +: PORT_MODE_W]),
      .evt_o  (evt_v)
    );

    port_status_reg #(.W(PIN_W)) u_status (
      .clk_i      (clk_i),
      .rst_ni     (rst_core_n),
      .evt_i      (evt_v),
      .clr_en_i   (clr_hit),
      .clr_mask_i (clr_mask_i),
      .status_o   (stat[p]),
      .irq_o      (irq_o[p])
    );

    assign status_bus_o[p*PIN_W +: PIN_W] = stat[p];
  end

  always_comb begin
    rd_data_o = '0;
    for (int p = 0; p < N_PORTS; p++) begin
      if (rd_sel_i == SEL_W'(p)) rd_data_o = stat[p];
    end
  end
endmodule

// File: rtl/wkup_status_checker.sv
module wkup_status_checker
  import wkup_pkg::*;
#(
  parameter int N_PORTS = 2,
  parameter int PIN_W   = 16,
  parameter int SEL_W   = 1
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic [N_PORTS*PIN_W*MODE_W-1:0] mode_i,
  input logic                            clr_we_i,
  input logic [SEL_W-1:0]                clr_port_i,
  input logic [SEL_W-1:0]                rd_sel_i,
  input logic [PIN_W-1:0]                rd_data_o,
  input logic [N_PORTS-1:0]              irq_o,
  input logic [N_PORTS*PIN_W-1:0]        status_bus_o
);
  for (genvar p = 0; p < N_PORTS; p++) begin : g_port_chk
    // R8: port interrupt follows any set bit of its port
    assert_irq_any_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[p] == (|status_bus_o[p*PIN_W +: PIN_W]));

    // R9: bits only drop after a clear aimed at this port
    assert_hold_unless_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(clr_we_i && (clr_port_i == SEL_W'(p))) |->
        ((status_bus_o[p*PIN_W +: PIN_W] & $past(status_bus_o[p*PIN_W +: PIN_W]))
          == $past(status_bus_o[p*PIN_W +: PIN_W])));

    // R11: read data mirrors the selected slice of the bus
    assert_rd_select_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_sel_i == SEL_W'(p)) |-> (rd_data_o == status_bus_o[p*PIN_W +: PIN_W]));
  end

  for (genvar k = 0; k < N_PORTS*PIN_W; k++) begin : g_bit_chk
    // R6: a bit can only rise if its pin had a valid trigger code
    assert_rise_needs_mode_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status_bus_o[k]) |->
        (($past(mode_i[MODE_W*k +: MODE_W]) >= 3'd1) &&
         ($past(mode_i[MODE_W*k +: MODE_W]) <= 3'd4)));
  end
endmodule

bind gpio_wake_latch wkup_status_checker #(
  .N_PORTS (N_PORTS),
  .PIN_W   (PIN_W),
  .SEL_W   (SEL_W)
) u_wkup_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_i       (mode_i),
  .clr_we_i     (clr_we_i),
  .clr_port_i   (clr_port_i),
  .rd_sel_i     (rd_sel_i),
  .rd_data_o    (rd_data_o),
  .irq_o        (irq_o),
  .status_bus_o (status_bus_o)
);

// File: tb/gpio_wake_latch_bench.sv
module gpio_wake_latch_bench;
  localparam int NP     = 2;
  localparam int PW     = 16;
  localparam int PERIOD = 10;

  logic               clk;
  logic               rst_n;
  logic [NP*PW-1:0]   pins;
  logic [NP*PW*3-1:0] mode;
  logic               clr_we;
  logic [0:0]         clr_port;
  logic [PW-1:0]      clr_mask;
  logic [0:0]         rd_sel;
  logic [PW-1:0]      rd_data;
  logic [NP-1:0]      irq;
  logic [NP*PW-1:0]   sbus;

  int checks = 0;
  int errors = 0;

  gpio_wake_latch u_gpio_wake_latch (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .pins_i       (pins),
    .mode_i       (mode),
    .clr_we_i     (clr_we),
    .clr_port_i   (clr_port),
    .clr_mask_i   (clr_mask),
    .rd_sel_i     (rd_sel),
    .rd_data_o    (rd_data),
    .irq_o        (irq),
    .status_bus_o (sbus)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // R12: mode field of pin i, port p at [3*(p*PW+i) +: 3]
  task automatic set_mode(input int p, input int i, input logic [2:0] c);
    mode[3*(p*PW+i) +: 3] = c;
  endtask

  task automatic set_pin(input int p, input int i, input logic v);
    pins[p*PW+i] = v;
  endtask

  function automatic logic [PW-1:0] port_stat(input int p);
    return sbus[p*PW +: PW];
  endfunction

  task automatic do_clear(input int p, input logic [PW-1:0] m);
    clr_we = 1'b1; clr_port = 1'(p); clr_mask = m;
    tick(1);
    clr_we = 1'b0; clr_mask = '0;
  endtask

  task automatic wipe();
    mode = '0;
    pins = '0;
    tick(4);
    do_clear(0, '1);
    do_clear(1, '1);
  endtask

  task automatic t_reset();
    check_eq("R1", "bus in reset", 32'(sbus), 32'h0);
    check_eq("R1", "irq in reset", 32'(irq), 32'h0);
    rst_n = 1'b1;
    tick(4);
    check_eq("R1", "bus after release", 32'(sbus), 32'h0);
    check_eq("R1", "irq after release", 32'(irq), 32'h0);
  endtask

  task automatic t_high_level();
    set_mode(0, 2, 3'd1);
    tick(1);
    set_pin(0, 2, 1'b1);
    tick(2);
    check_eq("R2", "not yet set after 2 edges", 32'(port_stat(0)), 32'h0);
    tick(1);
    check_eq("R2", "set on third edge", 32'(port_stat(0)), 32'h0004);
    check_eq("R7", "other port untouched", 32'(port_stat(1)), 32'h0);
    check_eq("R8", "irq port0 only", 32'(irq), 32'b01);
    do_clear(0, 16'h0004);
    tick(2);
    check_eq("R2", "level re-sets after clear", 32'(port_stat(0)), 32'h0004);
    set_pin(0, 2, 1'b0);
    tick(3);
    do_clear(0, 16'h0004);
    check_eq("R2", "cleared once level gone", 32'(port_stat(0)), 32'h0);
    check_eq("R8", "irq drops", 32'(irq), 32'b00);
    wipe();
  endtask

  task automatic t_low_level();
    set_pin(1, 3, 1'b1);
    tick(4);
    set_mode(1, 3, 3'd2);
    tick(3);
    check_eq("R3", "high pin no low event", 32'(port_stat(1)), 32'h0);
    set_pin(1, 3, 1'b0);
    tick(3);
    check_eq("R3", "low level sets", 32'(port_stat(1)), 32'h0008);
    check_eq("R8", "irq port1", 32'(irq), 32'b10);
    wipe();
  endtask

  task automatic t_rise();
    set_mode(1, 5, 3'd3);
    tick(1);
    set_pin(1, 5, 1'b1);
    tick(3);
    check_eq("R4", "rise sets", 32'(port_stat(1)), 32'h0020);
    do_clear(1, 16'h0020);
    tick(5);
    check_eq("R4", "once per edge", 32'(port_stat(1)), 32'h0);
    wipe();
  endtask

  task automatic t_fall();
    set_pin(1, 0, 1'b1);
    tick(4);
    set_mode(1, 0, 3'd4);
    tick(1);
    set_pin(1, 0, 1'b0);
    tick(3);
    check_eq("R5", "fall sets", 32'(port_stat(1)), 32'h0001);
    do_clear(1, 16'h0001);
    set_pin(1, 0, 1'b1);
    tick(5);
    check_eq("R5", "rise ignored", 32'(port_stat(1)), 32'h0);
    wipe();
  endtask

  task automatic t_disabled();
    set_mode(0, 8, 3'd0);
    set_mode(0, 9, 3'd5);
    set_mode(0, 10, 3'd6);
    set_mode(0, 11, 3'd7);
    for (int r = 0; r < 3; r++) begin
      pins[8 +: 4] = 4'hF;
      tick(4);
      pins[8 +: 4] = 4'h0;
      tick(4);
    end
    check_eq("R6", "unused codes never set", 32'(port_stat(0)), 32'h0);
    check_eq("R6", "no irq", 32'(irq), 32'b00);
    wipe();
  endtask

  task automatic t_clear_mask();
    set_mode(0, 0, 3'd3);
    set_mode(0, 1, 3'd3);
    set_mode(0, 4, 3'd3);
    set_mode(1, 1, 3'd3);
    tick(1);
    set_pin(0, 0, 1'b1); set_pin(0, 1, 1'b1); set_pin(0, 4, 1'b1);
    set_pin(1, 1, 1'b1);
    tick(4);
    check_eq("R7", "port0 bits", 32'(port_stat(0)), 32'h0013);
    check_eq("R7", "port1 bits", 32'(port_stat(1)), 32'h0002);
    do_clear(0, 16'h0001);
    check_eq("R9", "mask 0x1 clears pin0", 32'(port_stat(0)), 32'h0012);
    check_eq("R9", "other port kept", 32'(port_stat(1)), 32'h0002);
    do_clear(1, 16'h0002);
    check_eq("R9", "port1 cleared", 32'(port_stat(1)), 32'h0);
    check_eq("R9", "port0 kept", 32'(port_stat(0)), 32'h0012);
    check_eq("R8", "irq follows ports", 32'(irq), 32'b01);
    rd_sel = 1'b0;
    #1;
    check_eq("R11", "read port0", 32'(rd_data), 32'h0012);
    rd_sel = 1'b1;
    #1;
    check_eq("R11", "read port1", 32'(rd_data), 32'h0);
    check_eq("R11", "bus layout", sbus, 32'h0000_0012);
    rd_sel = 1'b0;
    wipe();
  endtask

  task automatic t_collision();
    set_mode(0, 7, 3'd3);
    tick(1);
    set_pin(0, 7, 1'b1);
    tick(4);
    set_pin(0, 7, 1'b0);
    tick(4);
    check_eq("R10", "first rise latched", 32'(port_stat(0)), 32'h0080);
    set_pin(0, 7, 1'b1);
    tick(2);
    do_clear(0, 16'h0080);
    check_eq("R10", "event beats clear", 32'(port_stat(0)), 32'h0080);
    do_clear(0, 16'h0080);
    check_eq("R10", "later clear works", 32'(port_stat(0)), 32'h0);
    wipe();
  endtask

  task automatic t_reset_midrun();
    set_mode(1, 9, 3'd3);
    tick(1);
    set_pin(1, 9, 1'b1);
    tick(4);
    check_eq("R1", "bit set before reset", 32'(port_stat(1)), 32'h0200);
    rst_n = 1'b0;
    tick(1);
    check_eq("R1", "reset clears status", 32'(sbus), 32'h0);
    check_eq("R1", "reset clears irq", 32'(irq), 32'h0);
    rst_n = 1'b1;
    tick(4);
    wipe();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pins = '0; mode = '0;
    clr_we = 1'b0; clr_port = '0; clr_mask = '0; rd_sel = '0;
    tick(3);
    t_reset();
    t_high_level();
    t_low_level();
    t_rise();
    t_fall();
    t_disabled();
    t_clear_mask();
    t_collision();
    t_reset_midrun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule